// File: doc/BRIEF.md
# Restartable Periodic Tick Timer

The block divides the system clock down to one tick every 20 ms. At the default system clock of 39.3216 MHz, one period is 786432 cycles. The divisor is a parameter, so a bench can run with a short period. Each tick sets a sticky ready flag and reloads the countdown. Software clears the ready flag with a dedicated control bit. When the interrupt enable is set, the ready flag is driven out as a level interrupt request.

Software reaches the block through a window of four 16-bit words, using a select strobe, a write strobe and a 2-bit word index. Index 0 is octal offset 10, index 1 is octal 11, index 2 is octal 12 and index 3 is octal 13.

A write to index 1 restarts the countdown, so the next tick comes exactly one period after that write. If software keeps writing index 1 more often than once per period, no tick ever occurs.

Top module: `rtc_tick`

## Requirements
- R1: While reset is asserted, and right after it is released, the status word reads 0 and irq_o is 0.
- R2: The first tick sets the ready flag at the PERIOD-th rising clock edge after reset is released. After each tick the countdown reloads, so later ticks follow every PERIOD edges.
- R3: A write to index 1 (any data) reloads the countdown. The ready flag then rises at the PERIOD-th edge after the write edge, and not before.
- R4: If index 1 is written again before the period expires, no tick occurs. This includes a write that lands in the same cycle as the expiry; that write cancels the tick.
- R5: A read of index 2 returns the status word: bit 0 is the interrupt enable, bit 3 is the ready flag, and all other bits are 0.
- R6: Reads of index 0, index 1 and index 3 return 0. Writes to index 0 and index 2 change no state.
- R7: A write to index 3 loads the interrupt enable from data bit 0. The enable is set when bit 0 is 1 and cleared when it is 0.
- R8: A write to index 3 with data bit 13 set clears the ready flag. Otherwise the ready flag stays set across further ticks.
- R9: If an expiry and a ready-clear write fall in the same cycle, the expiry wins and the ready flag stays set.
- R10: irq_o is high exactly when both the ready flag and the interrupt enable are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access strobe for the register window |
| we_i | input | 1 | 1 = write, 0 = read (qualified by sel_i) |
| addr_i | input | 2 | Word index in the window (0..3 = octal offsets 10..13) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational; 0 when not reading) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench pins down exact tick timing after reset and after a restart write, sampling one cycle before and at the expected edge. An off-by-one reload or a restart that leaves the counter running would show ready one cycle early or late.

It goes after the two same-cycle collisions:
- A restart written in the expiry cycle must swallow the tick. A design that lets the expiry through would show ready one period too early.
- A ready-clear written in the expiry cycle must lose to the expiry. A design that lets the clear win would show ready low and no interrupt.

Repeated restarts must starve the tick completely. Writes to the unused and read-only words must leave the enable and ready state untouched.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 2;

  // word index inside the window (octal offsets 10..13)
  localparam logic [ADDR_W-1:0] IDX_NONE    = 2'd0;
  localparam logic [ADDR_W-1:0] IDX_RESTART = 2'd1;
  localparam logic [ADDR_W-1:0] IDX_STATUS  = 2'd2;
  localparam logic [ADDR_W-1:0] IDX_CTRL    = 2'd3;

  // bit positions software decodes
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_READY = 3;
  localparam int unsigned BIT_CLR   = 13;
endpackage

// File: rtl/rtc_period_cnt.sv
module rtc_period_cnt #(
  parameter int unsigned PERIOD = 786432,
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  // a restart in the expiry cycle swallows the tick
  assign expire_o = (cnt_q == '0) && !restart_i;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= RELOAD;
    else if (restart_i || cnt_q == '0)   cnt_q <= RELOAD;
    else                                 cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic ctrl_we_i,
  input  logic en_d_i,
  input  logic clr_i,
  output logic ready_o,
  output logic en_o
);
  logic ready_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (expire_i)                  ready_q <= 1'b1;  // expiry beats clear
      else if (ctrl_we_i && clr_i)   ready_q <= 1'b0;
      if (ctrl_we_i)                 en_q    <= en_d_i;
    end
  end

  assign ready_o = ready_q;
  assign en_o    = en_q;
endmodule

// File: rtl/rtc_tick.sv
module rtc_tick
  import rtc_pkg::*;
#(
  parameter int unsigned PERIOD = 786432,
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             wr, rd, restart, ctrl_we, expire, ready_q, en_q;
  logic [CNT_W-1:0] cnt_q;

  assign wr      = sel_i && we_i;
  assign rd      = sel_i && !we_i;
  assign restart = wr && (addr_i == IDX_RESTART);
  assign ctrl_we = wr && (addr_i == IDX_CTRL);

  rtc_period_cnt #(.PERIOD(PERIOD)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .expire_o  (expire),
    .cnt_o     (cnt_q)
  );

  rtc_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .ctrl_we_i (ctrl_we),
    .en_d_i    (wdata_i[BIT_EN]),
    .clr_i     (wdata_i[BIT_CLR]),
    .ready_o   (ready_q),
    .en_o      (en_q)
  );

  always_comb begin
    rdata_o = '0;
    if (rd && addr_i == IDX_STATUS) begin
      rdata_o[BIT_EN]    = en_q;
      rdata_o[BIT_READY] = ready_q;
    end
  end

  assign irq_o = ready_q & en_q;
endmodule

// File: rtl/rtc_tick_chk.sv
module rtc_tick_chk
  import rtc_pkg::*;
#(
  parameter int unsigned PERIOD = 786432,
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              expire,
  input logic              ready_q,
  input logic              en_q
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

  AST_READY_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> $past(cnt_q) == '0); // R2

  AST_RESTART_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == IDX_RESTART) |=> cnt_q == RELOAD); // R3

  AST_RESTART_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == IDX_RESTART && !ready_q) |=> !ready_q); // R4

  AST_STATUS_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~DATA_W'(16'h0009)) == '0); // R5

  AST_READ_OTHER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && addr_i != IDX_STATUS) |-> rdata_o == '0); // R6

  AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == IDX_CTRL) |=> en_q == $past(wdata_i[BIT_EN])); // R7

  AST_CLEAR_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == IDX_CTRL && wdata_i[BIT_CLR] && !expire) |=> !ready_q); // R8

  AST_EXPIRY_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> ready_q); // R9

  AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q && ready_q)); // R10
endmodule

bind rtc_tick rtc_tick_chk #(.PERIOD(PERIOD)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .cnt_q   (cnt_q),
  .expire  (expire),
  .ready_q (ready_q),
  .en_q    (en_q)
);

// File: tb/rtc_tick_bench.sv
module rtc_tick_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_tick #(.PERIOD(P)) u_rtc_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // {we, addr, wdata, expected rdata, expected irq}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0},  // R6 index 0 reads 0
    {1'b0, 2'd2, 16'h0000, 16'h0000, 1'b0},  // R5 status idle
    {1'b1, 2'd3, 16'h0001, 16'h0000, 1'b0},  // R7 enable on
    {1'b0, 2'd2, 16'h0000, 16'h0001, 1'b0},  // R5 bit0 = enable
    {1'b0, 2'd1, 16'h0000, 16'h0000, 1'b0},  // R6 index 1 reads 0
    {1'b0, 2'd3, 16'h0000, 16'h0000, 1'b0},  // R6 index 3 reads 0
    {1'b1, 2'd0, 16'hFFFF, 16'h0000, 1'b0},  // R6 write idx0 ignored
    {1'b1, 2'd2, 16'hFFFE, 16'h0000, 1'b0},  // R6 write idx2 ignored
    {1'b0, 2'd2, 16'h0000, 16'h0001, 1'b0},  // R6 enable kept
    {1'b1, 2'd3, 16'h0000, 16'h0000, 1'b0},  // R7 enable off
    {1'b0, 2'd2, 16'h0000, 16'h0000, 1'b0},  // R7 status shows off
    {1'b0, 2'd2, 16'h0000, 16'h0000, 1'b0}   // R10 irq low
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_status(output logic [15:0] v);
    sel_i = 1'b1; we_i = 1'b0; addr_i = 2'd2;
    #1 v = rdata_o;
    sel_i = 1'b0;
  endtask

  task automatic chk_ready(input string req, input logic exp);
    logic [15:0] v;
    rd_status(v);
    check(req, {15'h0, v[3]}, {15'h0, exp});
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0; wdata_i = 16'h0;
  endtask

  initial begin
    logic [15:0] v;
    // R1 reset state
    #(CLK_PERIOD*3);
    rd_status(v);
    check("R1 status in reset", v, 16'h0000);
    check("R1 irq in reset", {15'h0, irq_o}, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_status(v);
    check("R1 status after release", v, 16'h0000);

    // R2 first tick at edge P after release
    repeat (P-1) @(negedge clk_i);
    chk_ready("R2 no tick before P", 1'b0);
    @(negedge clk_i);
    chk_ready("R2 tick at P", 1'b1);

    // clear and re-phase before the table
    wr(2'd3, 16'h2000);
    chk_ready("R8 cleared", 1'b0);
    wr(2'd1, 16'h0);

    for (int i = 0; i < NV; i++) begin
      sel_i = 1'b1; we_i = VEC[i][35]; addr_i = VEC[i][34:33]; wdata_i = VEC[i][32:17];
      #1;
      if (!VEC[i][35]) check($sformatf("vector %0d rdata", i), rdata_o, VEC[i][16:1]);
      check($sformatf("R10 vector %0d irq", i), {15'h0, irq_o}, {15'h0, VEC[i][0]});
      @(posedge clk_i);
      @(negedge clk_i);
      sel_i = 1'b0; we_i = 1'b0; wdata_i = 16'h0;
    end

    // R3 exact restart timing
    wr(2'd1, 16'h1234);
    repeat (P-1) @(negedge clk_i);
    chk_ready("R3 no tick before P", 1'b0);
    @(negedge clk_i);
    chk_ready("R3 tick at P after restart", 1'b1);
    check("R10 irq low while disabled", {15'h0, irq_o}, 16'h0);

    // R2/R8 ready sticks over another period
    repeat (P) @(negedge clk_i);
    chk_ready("R8 ready sticky", 1'b1);
    wr(2'd3, 16'h0001);
    chk_ready("R8 ready kept without bit13", 1'b1);
    check("R10 irq high", {15'h0, irq_o}, 16'h1);
    wr(2'd3, 16'h2001);
    chk_ready("R8 ready cleared", 1'b0);
    check("R10 irq low after clear", {15'h0, irq_o}, 16'h0);

    // R4 repeated restarts starve the tick
    for (int k = 0; k < 5; k++) begin
      wr(2'd1, 16'h0);
      repeat (P/2) @(negedge clk_i);
    end
    chk_ready("R4 no tick with repeated restart", 1'b0);

    // R9 expiry wins over clear
    wr(2'd1, 16'h0);
    repeat (P-1) @(negedge clk_i);
    wr(2'd3, 16'h2001);
    chk_ready("R9 expiry beats clear", 1'b1);
    check("R9 irq with enable", {15'h0, irq_o}, 16'h1);

    // R4 restart in expiry cycle cancels tick
    wr(2'd3, 16'h2001);
    chk_ready("R8 clear before collision", 1'b0);
    wr(2'd1, 16'h0);
    repeat (P-1) @(negedge clk_i);
    wr(2'd1, 16'h0);
    chk_ready("R4 restart cancels expiry", 1'b0);
    repeat (P-1) @(negedge clk_i);
    chk_ready("R4 no tick before new period", 1'b0);
    @(negedge clk_i);
    chk_ready("R4 tick after new period", 1'b1);
    check("R10 irq after tick", {15'h0, irq_o}, 16'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule